// File: doc/BRIEF.md
# Addressed Expansion Bus SPI Initiator

This block drives an addressed expansion bus that runs over a four-wire SPI link (mode 0, most significant bit first) with an active-low chip select. A host hands it one request at a time: read or write, a 16-bit target address, a byte count and up to fifteen bytes of write data. The block frames the whole exchange on the wire, spaces the bytes so a slow target can reload its shift register, and reports completion with a single-cycle done pulse.

Each frame opens with the target address, low byte first, then a command byte whose upper nibble names the operation and whose lower nibble carries the byte count. Writes then stream the data bytes and close the frame. Reads fetch a status byte first. When the status is not ready, or when the trailing checksum byte disagrees with the modulo-256 sum of the received data, the block releases chip select, waits a recovery gap and replays the full frame. After a bounded number of attempts it gives up and flags an error.

Top module: `xbus_spi_master`

## Requirements
- R1: A frame begins with spi_cs_n falling, followed by the address low byte (req_addr[7:0]) and then the address high byte (req_addr[15:8]).
- R2: The third byte of every frame is the command: bits 7:4 are 0x3 for a write (req_write=1) or 0x2 for a read, bits 3:0 the byte count; a req_len above 15 is clamped to 15 for both operations.
- R3: A write sends the byte count's worth of data bytes after the command, byte i taken from req_wdata[8i+7:8i] in increasing i, ignores what arrives on spi_miso, raises spi_cs_n after the last data byte, and completes with error=0 and xfer_count equal to the byte count.
- R4: A read exchanges one status byte (spi_mosi sends 0x00) after the command; only the value 0x02 is accepted, and any other value ends the frame there, raises spi_cs_n, holds it high for at least cfg_recover cycles and restarts from the address bytes.
- R5: After a ready status a read exchanges the data bytes and then one checksum byte, all sending 0x00; received data byte i lands in rd_data[8i+7:8i], and when the checksum equals the modulo-256 sum of the data the read completes with error=0 and xfer_count equal to the byte count, otherwise the frame is retried as in R4.
- R6: A read is attempted at most MAX_TRIES (default 10) times; when the last attempt fails, done comes with error=1 and xfer_count=0.
- R7: SPI mode 0: spi_sclk is low whenever spi_cs_n is high, spi_mosi does not change while spi_sclk is high, spi_miso is sampled on the rising edge, and each spi_sclk high phase lasts CLK_DIV clock cycles.
- R8: spi_sclk stays low for at least cfg_gap plus CLK_DIV cycles after spi_cs_n falls and between two bytes; spi_cs_n stays high for at least cfg_gap cycles before a successful done and at least cfg_recover cycles before a failed done or a retry, and never changes in the middle of a byte.
- R9: done is a single-cycle pulse; busy is high from the accepted request until done, and req_valid while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Target address |
| req_len | input | 8 | Requested byte count, clamped to 15 |
| req_wdata | input | 120 | Write bytes, byte i at bits 8i+7:8i |
| cfg_gap | input | GAP_W | Idle gap between bytes and around chip select, in clock cycles |
| cfg_recover | input | GAP_W | Chip-select-high gap after a failed read attempt |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Read failed on every attempt (valid with done) |
| xfer_count | output | 4 | Bytes transferred, zero on error (valid with done) |
| rd_data | output | 120 | Read bytes, byte i at bits 8i+7:8i |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench plays the target with a behavioural responder and a per-clock protocol model, then drives writes of ordinary, zero and over-long length, which separate correct data ordering from the clamp and from the empty-frame path. Reads run clean, with several not-ready statuses, with a corrupted checksum, with zero length and with more failures than the attempt limit, so the status gate, the checksum retry and the give-up path each show up as a distinct frame count and result. A second request pulsed in the middle of a transaction shows whether the block latches anything while busy.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int MAX_BYTES = 15;
    localparam int LEN_W     = 4;

    localparam logic [3:0] OP_WRITE_NIB = 4'h3;
    localparam logic [3:0] OP_READ_NIB  = 4'h2;
    localparam logic [7:0] STATUS_READY = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_WAIT,
        ST_SHIFT,
        ST_RELEASE
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_ADDR_LO,
        PH_ADDR_HI,
        PH_CMD,
        PH_STATUS,
        PH_DATA,
        PH_SUM
    } phase_t;

    typedef struct packed {
        logic             is_write;
        logic [15:0]      addr;
        logic [LEN_W-1:0] len;
    } txn_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [7:0] n);
        return (n > 8'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : n[LEN_W-1:0];
    endfunction

    function automatic logic [7:0] cmd_byte(input logic wr, input logic [LEN_W-1:0] len);
        return {(wr ? OP_WRITE_NIB : OP_READ_NIB), len};
    endfunction

endpackage

// File: rtl/xbus_shifter.sv
module xbus_shifter #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic             sclk_q;
    logic             busy_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                sh_q   <= tx_byte;
                bit_q  <= '0;
                div_q  <= '0;
                sclk_q <= 1'b0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (div_q == DIV_W'(DIV - 1)) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        sh_q   <= {sh_q[6:0], 1'b0};
                        bit_q  <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = sh_q[7];

    // R7: data line holds while the clock is high
    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(sh_q[7]));

    // R7: a new byte is only launched on an idle shifter
    p_start_idle_r7: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/xbus_gap_timer.sv
module xbus_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R8: once elapsed, the gap stays elapsed until reloaded
    p_stay_expired_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);

endmodule

// File: rtl/xbus_spi_master.sv
module xbus_spi_master
    import xbus_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int GAP_W     = 8,
    parameter int MAX_TRIES = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [15:0]                req_addr,
    input  logic [7:0]                 req_len,
    input  logic [MAX_BYTES*8-1:0]     req_wdata,
    input  logic [GAP_W-1:0]           cfg_gap,
    input  logic [GAP_W-1:0]           cfg_recover,
    output logic                       busy,
    output logic                       done,
    output logic                       error,
    output logic [LEN_W-1:0]           xfer_count,
    output logic [MAX_BYTES*8-1:0]     rd_data,
    output logic                       spi_sclk,
    output logic                       spi_mosi,
    input  logic                       spi_miso,
    output logic                       spi_cs_n
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    seq_state_t                   state_q;
    phase_t                       phase_q;
    txn_t                         txn_q;
    logic [MAX_BYTES-1:0][7:0]    wdata_q;
    logic [MAX_BYTES-1:0][7:0]    rdata_q;
    logic [LEN_W-1:0]             idx_q;
    logic [7:0]                   sum_q;
    logic [TRY_W-1:0]             tries_q;
    logic                         fail_q;
    logic                         cs_n_q;
    logic                         done_q;
    logic                         error_q;
    logic [LEN_W-1:0]             count_q;

    logic                         sh_start;
    logic [7:0]                   sh_tx;
    logic                         sh_busy;
    logic                         sh_done;
    logic [7:0]                   sh_rx;
    logic                         gap_load;
    logic [GAP_W-1:0]             gap_val;
    logic                         gap_expired;

    phase_t                       nxt_phase;
    logic                         nxt_end;
    logic                         nxt_fail;
    logic                         last_data;

    xbus_shifter #(.DIV(CLK_DIV)) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    xbus_gap_timer #(.W(GAP_W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .value   (gap_val),
        .expired (gap_expired)
    );

    // Byte presented to the wire for the current phase
    always_comb begin
        case (phase_q)
            PH_ADDR_LO: sh_tx = txn_q.addr[7:0];
            PH_ADDR_HI: sh_tx = txn_q.addr[15:8];
            PH_CMD:     sh_tx = cmd_byte(txn_q.is_write, txn_q.len);
            PH_DATA:    sh_tx = txn_q.is_write ? wdata_q[idx_q] : 8'h00;
            default:    sh_tx = 8'h00;
        endcase
    end

    // Frame progression after a completed byte
    always_comb begin
        nxt_phase = phase_q;
        nxt_end   = 1'b0;
        nxt_fail  = 1'b0;
        last_data = (idx_q == txn_q.len - 4'd1);
        case (phase_q)
            PH_ADDR_LO: nxt_phase = PH_ADDR_HI;
            PH_ADDR_HI: nxt_phase = PH_CMD;
            PH_CMD: begin
                if (!txn_q.is_write)          nxt_phase = PH_STATUS;
                else if (txn_q.len == '0)     nxt_end   = 1'b1;
                else                          nxt_phase = PH_DATA;
            end
            PH_STATUS: begin
                if (sh_rx != STATUS_READY) begin
                    nxt_end  = 1'b1;
                    nxt_fail = 1'b1;
                end else if (txn_q.len == '0) begin
                    nxt_phase = PH_SUM;
                end else begin
                    nxt_phase = PH_DATA;
                end
            end
            PH_DATA: begin
                if (last_data) begin
                    if (txn_q.is_write) nxt_end   = 1'b1;
                    else                nxt_phase = PH_SUM;
                end
            end
            PH_SUM: begin
                nxt_end  = 1'b1;
                nxt_fail = (sh_rx != sum_q);
            end
            default: nxt_end = 1'b1;
        endcase
    end

    assign sh_start = (state_q == ST_WAIT) && gap_expired;
    assign gap_load = (state_q == ST_SELECT) || ((state_q == ST_SHIFT) && sh_done);
    assign gap_val  = ((state_q == ST_SHIFT) && nxt_end && nxt_fail) ? cfg_recover : cfg_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_ADDR_LO;
            txn_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            idx_q   <= '0;
            sum_q   <= '0;
            tries_q <= '0;
            fail_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            error_q <= 1'b0;
            count_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        txn_q.is_write <= req_write;
                        txn_q.addr     <= req_addr;
                        txn_q.len      <= clamp_len(req_len);
                        wdata_q        <= req_wdata;
                        tries_q        <= TRY_W'(1);
                        state_q        <= ST_SELECT;
                    end
                end
                ST_SELECT: begin
                    cs_n_q  <= 1'b0;
                    phase_q <= PH_ADDR_LO;
                    idx_q   <= '0;
                    sum_q   <= '0;
                    fail_q  <= 1'b0;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (gap_expired) state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (phase_q == PH_DATA) begin
                            idx_q <= idx_q + 1'b1;
                            sum_q <= sum_q + sh_rx;
                            if (!txn_q.is_write) rdata_q[idx_q] <= sh_rx;
                        end
                        if (nxt_end) begin
                            cs_n_q  <= 1'b1;
                            fail_q  <= nxt_fail;
                            state_q <= ST_RELEASE;
                        end else begin
                            phase_q <= nxt_phase;
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (gap_expired) begin
                        if (fail_q && (tries_q < TRY_W'(MAX_TRIES))) begin
                            tries_q <= tries_q + 1'b1;
                            state_q <= ST_SELECT;
                        end else begin
                            done_q  <= 1'b1;
                            error_q <= fail_q;
                            count_q <= fail_q ? '0 : txn_q.len;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign error      = error_q;
    assign xfer_count = count_q;
    assign rd_data    = rdata_q;
    assign spi_cs_n   = cs_n_q;

    // R7: clock parked low whenever the target is deselected
    p_sclk_parked_r7: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R8: chip select moves only between bytes
    p_cs_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n_q) |-> !sh_busy);

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: a request seen while busy leaves the latched transaction untouched
    p_req_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(txn_q));

    // R6: error completion reports nothing valid
    p_err_count_r6: assert property (@(posedge clk) disable iff (rst)
        (done_q && error_q) |-> (count_q == '0));

    // R6: attempt counter never passes the limit
    p_tries_cap_r6: assert property (@(posedge clk) disable iff (rst)
        tries_q <= TRY_W'(MAX_TRIES));

endmodule

// File: tb/xbus_spi_master_bench.sv
module xbus_spi_master_bench;
    import xbus_pkg::*;

    localparam int DIV   = 2;
    localparam int MAXT  = 10;
    localparam int GAP   = 3;
    localparam int REC   = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [7:0]   req_len = '0;
    logic [119:0] req_wdata = '0;
    logic [7:0]   cfg_gap = 8'(GAP);
    logic [7:0]   cfg_recover = 8'(REC);
    logic         busy, done, error;
    logic [3:0]   xfer_count;
    logic [119:0] rd_data;
    logic         spi_sclk, spi_mosi, spi_cs_n;
    logic         spi_miso = 1'b0;

    always #5 clk = ~clk;

    xbus_spi_master #(.CLK_DIV(DIV), .GAP_W(8), .MAX_TRIES(MAXT)) u_xbus_spi_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .cfg_gap(cfg_gap), .cfg_recover(cfg_recover), .busy(busy), .done(done),
        .error(error), .xfer_count(xfer_count), .rd_data(rd_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int total = 0;
    int bad   = 0;

    function automatic void chk(input bit ok, input string req, input string what,
                                input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // Expected transaction and target behaviour
    logic        e_wr = 1'b0;
    logic [15:0] e_addr = '0;
    int          e_len = 0;
    logic [7:0]  e_sum = '0;
    logic [7:0]  rdat [15];
    int          stat_left = 0;
    int          sum_left = 0;
    int          frame_cnt = 0;

    // Per-clock wire model state
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
    int          hi_cnt = 0, lo_cnt = 0, cs_hi_cnt = 0, bitn = 0, bytek = 0;
    int          frames_in_txn = 0;
    logic [7:0]  txsh = '0, rxsh = '0;
    logic [7:0]  fb[$];

    function automatic logic [7:0] resp(input int k);
        if (k < 3) return 8'hA0 + 8'(k);
        if (e_wr) return 8'h5A;
        if (k == 3) return (stat_left > 0) ? 8'h03 : 8'h02;
        if (k < 4 + e_len) return rdat[k-4];
        if (k == 4 + e_len) return (sum_left > 0) ? e_sum + 8'd1 : e_sum;
        return 8'h00;
    endfunction

    task automatic end_frame();
        frame_cnt++;
        chk(fb.size() >= 3, "R1", "frame byte count", fb.size(), 3);
        if (fb.size() >= 3) begin
            chk(fb[0] == e_addr[7:0],  "R1", "address low",  fb[0], e_addr[7:0]);
            chk(fb[1] == e_addr[15:8], "R1", "address high", fb[1], e_addr[15:8]);
            chk(fb[2] == {(e_wr ? 4'h3 : 4'h2), 4'(e_len)}, "R2", "command byte",
                fb[2], {(e_wr ? 4'h3 : 4'h2), 4'(e_len)});
        end
        if (e_wr) begin
            chk(fb.size() == 3 + e_len, "R3", "write frame length", fb.size(), 3 + e_len);
            for (int i = 0; i < e_len && 3 + i < fb.size(); i++)
                chk(fb[3+i] == req_wdata[i*8 +: 8], "R3", "write data byte", fb[3+i], req_wdata[i*8 +: 8]);
        end else begin
            if (stat_left > 0) begin
                chk(fb.size() == 4, "R4", "not-ready frame length", fb.size(), 4);
                stat_left--;
            end else begin
                chk(fb.size() == 5 + e_len, "R5", "read frame length", fb.size(), 5 + e_len);
                if (sum_left > 0) sum_left--;
            end
            for (int i = 3; i < fb.size(); i++)
                chk(fb[i] == 8'h00, "R4", "dummy byte sent", fb[i], 0);
        end
    endtask

    // Reference model of the wire, compared every clock
    always @(negedge clk) begin
        if (!rst) begin
            chk(!(spi_cs_n && spi_sclk), "R7", "sclk low while deselected", spi_sclk, 0);
            if (spi_cs_n) cs_hi_cnt++;
            if (p_cs && !spi_cs_n) begin
                if (frames_in_txn > 0)
                    chk(cs_hi_cnt >= REC, "R4", "recovery gap", cs_hi_cnt, REC);
                frames_in_txn++;
                bytek = 0; bitn = 0; lo_cnt = 0;
                fb.delete();
                txsh = resp(0);
                spi_miso = txsh[7];
            end
            if (!p_cs && spi_cs_n) begin
                cs_hi_cnt = 1;
                end_frame();
            end
            if (!spi_cs_n) begin
                if (!p_sclk && spi_sclk) begin
                    if (bitn == 0)
                        chk(lo_cnt >= GAP + DIV, "R8", "idle gap before byte", lo_cnt, GAP + DIV);
                    rxsh = {rxsh[6:0], spi_mosi};
                    bitn++;
                    hi_cnt = 1;
                end else if (spi_sclk) begin
                    hi_cnt++;
                    chk(spi_mosi == p_mosi, "R7", "mosi stable while sclk high", spi_mosi, p_mosi);
                end
                if (p_sclk && !spi_sclk) begin
                    chk(hi_cnt == DIV, "R7", "sclk high phase", hi_cnt, DIV);
                    if (bitn == 8) begin
                        fb.push_back(rxsh);
                        bytek++;
                        bitn = 0;
                        lo_cnt = 1;
                        txsh = resp(bytek);
                    end else begin
                        txsh = {txsh[6:0], 1'b0};
                    end
                    spi_miso = txsh[7];
                end else if (!spi_sclk) begin
                    lo_cnt++;
                end
            end
            if (done)
                chk(cs_hi_cnt >= (error ? REC : GAP), "R8", "deselect time before done",
                    cs_hi_cnt, error ? REC : GAP);
            p_cs = spi_cs_n; p_sclk = spi_sclk; p_mosi = spi_mosi;
        end
    end

    task automatic run(input bit wr, input logic [15:0] addr, input int len_req,
                       input int sfail, input int cfail, input bit inject);
        int fails;
        int exp_frames;
        bit exp_err;
        int waited;
        e_wr = wr;
        e_addr = addr;
        e_len = (len_req > 15) ? 15 : len_req;
        e_sum = '0;
        for (int i = 0; i < 15; i++) begin
            rdat[i] = 8'((addr + i * 37 + 11) & 255);
            if (i < e_len) e_sum = e_sum + rdat[i];
            req_wdata[i*8 +: 8] = 8'((addr * 3 + i * 29 + 5) & 255);
        end
        stat_left = wr ? 0 : sfail;
        sum_left  = wr ? 0 : cfail;
        fails = wr ? 0 : sfail + cfail;
        exp_err = (fails >= MAXT);
        exp_frames = exp_err ? MAXT : fails + 1;
        frame_cnt = 0;
        frames_in_txn = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = 8'(len_req);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
        waited = 0;
        while (!done && waited < 40000) begin
            @(negedge clk);
            waited++;
            if (inject && waited == 40) begin
                req_valid = 1'b1; req_write = ~wr; req_addr = addr ^ 16'hFFFF; req_len = 8'd7;
            end
            if (inject && waited == 41) req_valid = 1'b0;
        end
        chk(done == 1'b1, "R9", "done seen", done, 1);
        chk(frame_cnt == exp_frames, exp_err ? "R6" : "R4", "frame count", frame_cnt, exp_frames);
        chk(error == exp_err, exp_err ? "R6" : "R5", "error flag", error, exp_err);
        chk(xfer_count == (exp_err ? 0 : e_len), wr ? "R3" : "R5", "byte count",
            xfer_count, exp_err ? 0 : e_len);
        if (!wr && !exp_err)
            for (int i = 0; i < e_len; i++)
                chk(rd_data[i*8 +: 8] == rdat[i], "R5", "read data byte", rd_data[i*8 +: 8], rdat[i]);
        chk(busy == 1'b0, "R9", "idle at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done single cycle", done, 0);
        if (inject) begin
            repeat (100) @(negedge clk);
            chk(frame_cnt == exp_frames && busy == 1'b0, "R9", "request while busy ignored",
                frame_cnt, exp_frames);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #1_900_000;
        total++; bad++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R7", "reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R7", "reset sclk", spi_sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R9", "reset busy/done", {busy, done}, 0);

        run(1'b1, 16'h1234, 3,  0, 0, 1'b0);   // R1 R3 plain write
        run(1'b1, 16'hBEEF, 20, 0, 0, 1'b0);   // R2 clamped write
        run(1'b1, 16'h00FF, 0,  0, 0, 1'b0);   // R3 empty write
        run(1'b0, 16'h4321, 4,  0, 0, 1'b0);   // R5 clean read
        run(1'b0, 16'h8001, 15, 2, 0, 1'b0);   // R4 status retries
        run(1'b0, 16'h0A0B, 2,  0, 1, 1'b0);   // R5 checksum retry
        run(1'b0, 16'h7777, 0,  0, 0, 1'b0);   // R5 empty read
        run(1'b0, 16'hC0DE, 12, 6, 6, 1'b0);   // R6 give up after limit
        run(1'b0, 16'h5555, 30, 1, 0, 1'b1);   // R2 R9 clamp and ignored request

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule